// File: doc/BRIEF.md
# Write-Lock Command Sequence Guard

This block sits in the write path of a small non-volatile memory model. It sees every byte-write strobe with its address and data. It looks for two fixed command sequences in that stream. A three-write arming sequence sets a persistent lock flag. A six-write release sequence clears it. While the flag is set, ordinary writes are refused. The write sequencer reads the qualifier `wr_permit` in the same cycle as the strobe and uses it to decide whether the byte goes into the page buffer.

A page-write burst that directly follows a complete arming sequence is allowed through, even when the memory is already locked. This holds for as long as the byte-load window stays open. A gap longer than `WINDOW` clock cycles between strobes closes the burst, drops that permission and sends the matcher back to its first step. A whole-array erase request is refused whenever the lock is set.

The lock flag models non-volatile state, so the ordinary reset `rst_n` leaves it alone. Only the separate cold-initialisation input `nv_init` forces it to the unprotected state, and only the release sequence clears it during operation.

Top module: `write_lock_guard`

## Requirements
- R1: After `nv_init` has been high for a clock edge, `locked` is 0. Asserting `rst_n` low later leaves `locked` unchanged.
- R2: The three consecutive strobes AAh at address 555h, then 55h at 2AAh, then A0h at 555h set `locked` to 1 from the clock edge of the third strobe.
- R3: While `locked` is 1 and no arming sequence has just completed, every strobe sees `wr_permit` = 0.
- R4: After an arming sequence completes, further strobes in the same burst see `wr_permit` = 1. Once the burst's load window has expired, they see 0.
- R5: The six consecutive strobes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 20h@555h clear `locked` from the edge of the sixth strobe. A deviation in the last three steps leaves `locked` at 1.
- R6: A strobe whose address or data differs from the expected step returns the matcher to its first step. That strobe is then qualified as an ordinary write under the current lock state, and a later correct tail does not complete the sequence.
- R7: Two strobes at most `WINDOW` clock edges apart belong to the same burst. A gap of `WINDOW`+1 edges or more resets the matcher.
- R8: `erase_permit` equals `erase_req` while `locked` is 0, and is 0 while `locked` is 1.
- R9: While `locked` is 0, every strobe, command bytes included, sees `wr_permit` = 1. With no strobe, `wr_permit` is 0.
- R10: Matching compares all 11 address bits and all 8 data bits. A single flipped bit in any step of the arming sequence leaves `locked` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for matcher and burst state (not the lock) |
| nv_init | input | 1 | Cold initialisation, clears the lock flag |
| wr_stb | input | 1 | One-cycle byte-write strobe |
| wr_addr | input | 11 | Byte address of the strobe |
| wr_data | input | 8 | Data byte of the strobe |
| erase_req | input | 1 | Whole-array erase request |
| locked | output | 1 | Persistent write-lock flag |
| wr_permit | output | 1 | Same-cycle qualifier: this strobe may reach the page buffer |
| erase_permit | output | 1 | Erase request passed on |

## Verification
The arming sequence is swept with every single-bit corruption of address and data at each of its three steps. This separates a full-width compare from a partial one, and a correct abort from a matcher that skips a step. Strobe gaps of exactly `WINDOW` and `WINDOW`+1 edges probe the edge of the load window, both inside a sequence and after a completed arming sequence. Aborted and completed release sequences, and a mismatch in the middle of an arming sequence, show that a stray write restarts matching rather than being absorbed. A reset pulse while locked shows that the lock survives reset.

// File: rtl/write_lock_guard.sv
module write_lock_guard #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter int WINDOW = 16,
  parameter logic [AW-1:0] ADDR_A = 11'h555,
  parameter logic [AW-1:0] ADDR_B = 11'h2AA,
  parameter logic [DW-1:0] KEY1 = 8'hAA,
  parameter logic [DW-1:0] KEY2 = 8'h55,
  parameter logic [DW-1:0] SET_CODE = 8'hA0,
  parameter logic [DW-1:0] CLR_PRE = 8'h80,
  parameter logic [DW-1:0] CLR_CODE = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_init,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          erase_req,
  output logic          locked,
  output logic          wr_permit,
  output logic          erase_permit
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [2:0]    step, step_n;
  logic          grant, burst, lock_q;
  logic [CW-1:0] idle;
  logic          set_ev, clr_ev;

  wire on_a    = (wr_addr == ADDR_A);
  wire hit_k1  = on_a && (wr_data == KEY1);
  wire hit_k2  = (wr_addr == ADDR_B) && (wr_data == KEY2);

  always_comb begin
    step_n = 3'd0;
    set_ev = 1'b0;
    clr_ev = 1'b0;
    case (step)
      3'd0: if (hit_k1) step_n = 3'd1;
      3'd1: if (hit_k2) step_n = 3'd2;
      3'd2: begin
        if (on_a && wr_data == SET_CODE) set_ev = 1'b1;
        else if (on_a && wr_data == CLR_PRE) step_n = 3'd3;
      end
      3'd3: if (hit_k1) step_n = 3'd4;
      3'd4: if (hit_k2) step_n = 3'd5;
      3'd5: if (on_a && wr_data == CLR_CODE) clr_ev = 1'b1;
      default: step_n = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step  <= 3'd0;
      burst <= 1'b0;
      grant <= 1'b0;
      idle  <= '0;
    end else if (wr_stb) begin
      step  <= step_n;
      burst <= 1'b1;
      idle  <= '0;
      if (set_ev) grant <= 1'b1;
      else if (clr_ev) grant <= 1'b0;
    end else if (burst) begin
      if (idle == CW'(WINDOW - 1)) begin
        burst <= 1'b0;
        step  <= 3'd0;
        grant <= 1'b0;
      end else begin
        idle <= idle + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (nv_init) lock_q <= 1'b0;
    else if (wr_stb && set_ev) lock_q <= 1'b1;
    else if (wr_stb && clr_ev) lock_q <= 1'b0;
  end

  assign locked       = lock_q;
  assign wr_permit    = wr_stb && (!lock_q || grant);
  assign erase_permit = erase_req && !lock_q;
endmodule

// File: rtl/write_lock_guard_chk.sv
module write_lock_guard_chk #(
  parameter int AW = 11,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_A = 11'h555,
  parameter logic [DW-1:0] SET_CODE = 8'hA0,
  parameter logic [DW-1:0] CLR_CODE = 8'h20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nv_init,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          erase_req,
  input logic          locked,
  input logic          wr_permit,
  input logic          erase_permit
);
  assert_lock_moves_on_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> ($past(wr_stb) || $past(nv_init)));

  assert_set_only_by_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(wr_stb && wr_addr == ADDR_A && wr_data == SET_CODE));

  assert_clear_only_by_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(locked) && !$past(nv_init)) |-> $past(wr_stb && wr_addr == ADDR_A && wr_data == CLR_CODE));

  assert_erase_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || !erase_req) |-> !erase_permit);

  assert_erase_passed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !locked) |-> erase_permit);

  assert_open_permits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !locked) |-> wr_permit);

  assert_no_strobe_no_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> !wr_permit);
endmodule

bind write_lock_guard write_lock_guard_chk #(
  .AW(AW), .DW(DW), .ADDR_A(ADDR_A), .SET_CODE(SET_CODE), .CLR_CODE(CLR_CODE)
) u_chk (.*);

// File: tb/tb_write_lock_guard.sv
module tb_write_lock_guard;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nv_init = 1'b1;
  logic wr_stb = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic erase_req = 1'b0;
  logic locked, wr_permit, erase_permit;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  write_lock_guard #(.WINDOW(WIN)) dut (
    .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_req(erase_req),
    .locked(locked), .wr_permit(wr_permit), .erase_permit(erase_permit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [10:0] a, input logic [7:0] d, output logic p);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #5 p = wr_permit;
    @(posedge clk);
    #1 wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic arm(input int g1, input int g2);
    logic p;
    put(11'h555, 8'hAA, p); idle(g1);
    put(11'h2AA, 8'h55, p); idle(g2);
    put(11'h555, 8'hA0, p);
  endtask

  initial begin
    idle(200000);
    fails++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic p;
    logic [10:0] sa [3];
    logic [7:0] sd [3];
    sa[0] = 11'h555; sd[0] = 8'hAA;
    sa[1] = 11'h2AA; sd[1] = 8'h55;
    sa[2] = 11'h555; sd[2] = 8'hA0;

    idle(3);
    @(negedge clk); nv_init = 1'b0; rst_n = 1'b1;
    idle(1); #1;
    chk("R1 reset state locked", locked, 0);
    chk("R9 no strobe permit", wr_permit, 0);
    erase_req = 1'b1; #1;
    chk("R8 erase open", erase_permit, 1);
    erase_req = 1'b0;

    for (int i = 0; i < 8; i++) begin
      put(11'(i * 257), 8'(i * 37 + 1), p);
      chk("R9 open write permit", p, 1);
    end
    idle(WIN + 2);

    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < 19; b++) begin
        for (int k = 0; k < 3; k++) begin
          logic [10:0] a = sa[k];
          logic [7:0] d = sd[k];
          if (k == s) begin
            if (b < 11) a = a ^ (11'd1 << b);
            else d = d ^ (8'd1 << (b - 11));
          end
          put(a, d, p);
          if (k == s) chk("R6 mismatch write open permit", p, 1);
        end
        idle(WIN + 2); #1;
        chk("R10 corrupted arm no lock", locked, 0);
      end
    end

    arm(0, 0); #1;
    chk("R2 arm sets lock", locked, 1);
    for (int i = 0; i < 3; i++) begin
      put(11'h040 + 11'(i), 8'h3C, p);
      chk("R4 granted page write", p, 1);
    end
    idle(WIN); put(11'h041, 8'h3C, p);
    chk("R4 grant gone after window", p, 0);
    idle(WIN + 2);

    @(negedge clk); rst_n = 1'b0; idle(2);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 lock survives reset", locked, 1);
    erase_req = 1'b1; #1;
    chk("R8 erase blocked", erase_permit, 0);
    erase_req = 1'b0;

    for (int i = 0; i < 6; i++) begin
      put(11'(i * 300 + 7), 8'(i * 41), p);
      chk("R3 locked write blocked", p, 0);
    end
    idle(WIN + 2);

    arm(WIN - 1, WIN - 1);
    put(11'h100, 8'h11, p);
    chk("R7 max gap keeps sequence", p, 1);
    idle(WIN + 2);

    arm(0, WIN);
    put(11'h100, 8'h11, p);
    chk("R7 over gap breaks sequence", p, 0);
    idle(WIN + 2);

    put(11'h555, 8'hAA, p); put(11'h2AA, 8'h55, p);
    put(11'h100, 8'h12, p);
    chk("R6 mid-sequence mismatch locked blocked", p, 0);
    put(11'h555, 8'hA0, p); put(11'h101, 8'h13, p);
    chk("R6 tail after abort no grant", p, 0);
    idle(WIN + 2);

    put(11'h555, 8'hAA, p); put(11'h2AA, 8'h55, p); put(11'h555, 8'h80, p);
    put(11'h555, 8'hAA, p); put(11'h2AA, 8'h55, p); put(11'h555, 8'h21, p);
    #1; chk("R5 wrong release code keeps lock", locked, 1);
    idle(WIN + 2);

    put(11'h555, 8'hAA, p); put(11'h2AA, 8'h55, p); put(11'h555, 8'h80, p);
    put(11'h555, 8'hAA, p); put(11'h2AA, 8'h55, p); put(11'h555, 8'h20, p);
    chk("R5 release write itself blocked", p, 0);
    #1; chk("R5 release clears lock", locked, 0);
    put(11'h200, 8'h77, p);
    chk("R9 write open after release", p, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule